// File: doc/BRIEF.md
# Serial Packet Receiver

This block sits behind a line-state sampler that has already recovered the bit clock. At each bit time it takes one symbol: the line is either in the J state, in the K state, or in single-ended zero (SE0). The block finds the start-of-packet sync pattern, removes the NRZI coding and the stuffed bits, and gathers the bit stream into bytes, least significant bit first. It then checks the packet identifier byte and sorts the packet into one of four groups: token, data, short (handshake or preamble), or undefined.

Token packets are split into their fields and their 5-bit CRC is checked. Each byte of a data packet after the identifier is passed on with a strobe. At the end of each packet the block gives a one-cycle report with the type code, the token fields and five error flags.

Neither the line nor the byte output can be stalled, so the block has no back-pressure. The symbol input is qualified by `sym_vld`, and the sampler may leave any number of idle clocks between symbols. The byte output is a strobe that the consumer must accept in the cycle it appears.

Top module: `srx_top`

## Requirements
- R1: A packet starts only after eight consecutive non-SE0 symbols K J K J K J K K. Line activity without this sequence produces no packet report and no data byte.
- R2: Within a packet, a symbol equal to the one before it decodes as bit 1 and a change decodes as bit 0. The first bit is compared with the final K of the sync sequence.
- R3: After six decoded 1 bits in a row, the next bit is discarded when it is 0. When that bit is 1, `err_stuff` is raised in the report and every later bit of that packet is ignored.
- R4: Bytes are assembled least significant bit first. In the first byte, bits 3:0 are the type code and bits 7:4 must be its bitwise inverse. The type code must also be one of OUT=0001, IN=1001, SOF=0101, SETUP=1101, DATA0=0011, DATA1=1011, ACK=0010, NAK=1010, STALL=1110 or PRE=1100. If either check fails, `err_pid` is raised. `pkt_type` always shows bits 3:0 of the first byte, or 0 when the packet has no complete byte.
- R5: Let the 16-bit field be byte1 + 256*byte2. For IN, OUT and SETUP with a good identifier, `tok_addr` is field bits 6:0 and `tok_ep` is field bits 10:7. For every other packet both are zero.
- R6: For SOF with a good identifier, `tok_frame` is field bits 10:0. For every other packet it is zero.
- R7: The check value is computed over field bits 0 to 10, in that order, with a 5-bit register preset to 11111 and the polynomial x^5+x^2+1. The result is then inverted. Check bit 4 must be in field bit 11, and so on down to check bit 0 in field bit 15. A mismatch in a 3-byte token raises `err_crc`.
- R8: `err_len` is raised in four cases: a token that is not exactly 3 bytes long, a handshake or PRE packet that is not exactly 1 byte long, a data packet with no identifier byte, or any packet with no complete byte. When `err_pid` is raised, both `err_len` and `err_crc` stay low.
- R9: A packet ends when a run of SE0 symbols is followed by a non-SE0 symbol. `err_eop` is raised in three cases: the run was shorter than two symbols, the closing symbol is K, or the number of decoded bits is not a multiple of 8. A run of two or more SE0 symbols followed by J is a clean end.
- R10: The report appears as a single-cycle `pkt_vld` pulse, exactly once per packet. All fields and error flags are valid in that cycle. After reset, `pkt_vld` and `dat_vld` are low.
- R11: For DATA0 and DATA1 with a good identifier, every complete byte after the identifier appears on `dat_byte` with a one-cycle `dat_vld`, in arrival order. Packets of any other type produce no data strobe.
- R12: Clocks with `sym_vld` low are ignored. Decoding is the same whether symbols arrive on every clock or with idle clocks between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sym_vld | input | 1 | A symbol is present this clock |
| sym_j | input | 1 | Line state: 1 for J, 0 for K |
| sym_se0 | input | 1 | Line is in SE0 (sym_j is then ignored) |
| pkt_vld | output | 1 | End-of-packet report strobe |
| pkt_type | output | 4 | Type code from the identifier byte |
| tok_addr | output | 7 | Function address of IN/OUT/SETUP |
| tok_ep | output | 4 | Endpoint number of IN/OUT/SETUP |
| tok_frame | output | 11 | Frame number of SOF |
| err_pid | output | 1 | Identifier complement or code error |
| err_crc | output | 1 | Token check value mismatch |
| err_stuff | output | 1 | Seven 1 bits in a row |
| err_eop | output | 1 | Malformed end or partial final byte |
| err_len | output | 1 | Byte count wrong for the type |
| dat_vld | output | 1 | Data payload byte strobe |
| dat_byte | output | 8 | Data payload byte |

## Verification
The first group of packets uses tokens with well-chosen fields. An address and endpoint made entirely of ones forces stuffed bits inside the field. A SETUP with one flipped check bit tells a real check-value comparison apart from one that never fires. SOF and IN tokens show that the field is routed to frame or to address and endpoint by type.

Data packets carry long runs of ones and zeros. Their payload bytes are compared one by one, which tells unstuffing and LSB-first packing apart from near-miss variants. The same packets are sent with idle clocks between symbols.

A set of malformed packets each tests one error flag on its own, and shows that no other flag is raised with it. The set covers a bad complement, an undefined code, short and long tokens and handshakes, an empty packet, a seventh 1 bit, a partial final byte, a one-symbol SE0, and a K after SE0. A final burst of sync-like noise must produce nothing at all.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [3:0] {
    PID_OUT   = 4'b0001,
    PID_IN    = 4'b1001,
    PID_SOF   = 4'b0101,
    PID_SETUP = 4'b1101,
    PID_DATA0 = 4'b0011,
    PID_DATA1 = 4'b1011,
    PID_ACK   = 4'b0010,
    PID_NAK   = 4'b1010,
    PID_STALL = 4'b1110,
    PID_PRE   = 4'b1100
  } pid_e;

  typedef enum logic [1:0] {
    CLS_TOKEN,
    CLS_DATA,
    CLS_SHORT,
    CLS_BAD
  } pid_cls_e;

  // Sync sequence in arrival order, oldest symbol in bit 7 (J=1, K=0).
  localparam logic [7:0] SYNC_PAT = 8'b0101_0100;

  function automatic pid_cls_e classify(input logic [3:0] p);
    case (p)
      PID_OUT, PID_IN, PID_SOF, PID_SETUP:   return CLS_TOKEN;
      PID_DATA0, PID_DATA1:                  return CLS_DATA;
      PID_ACK, PID_NAK, PID_STALL, PID_PRE:  return CLS_SHORT;
      default:                               return CLS_BAD;
    endcase
  endfunction

  // Serial five-bit check over eleven field bits, bit 0 first.
  function automatic logic [4:0] crc5_calc(input logic [10:0] d);
    logic [4:0] r;
    logic       fb;
    r = 5'b11111;
    for (int i = 0; i < 11; i++) begin
      fb = r[4] ^ d[i];
      r  = {r[3:0], 1'b0};
      if (fb) r = r ^ 5'b00101;
    end
    return ~r;
  endfunction

endpackage

// File: rtl/srx_line.sv
module srx_line
  import srx_pkg::*;
#(
  parameter int RUN_MAX = 6,
  parameter int EOP_MIN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sym_vld,
  input  logic sym_j,
  input  logic sym_se0,
  output logic bit_vld,
  output logic bit_val,
  output logic sop,
  output logic eop,
  output logic stuff_err,
  output logic eop_err
);
  localparam int OW = $clog2(RUN_MAX + 1);
  localparam int SW = $clog2(EOP_MIN + 1);
  localparam logic [OW-1:0] ONES_LIM = OW'(RUN_MAX);
  localparam logic [SW-1:0] SE_LIM   = SW'(EOP_MIN);

  logic          in_pkt;
  logic          drop;
  logic          prev_j;
  logic [6:0]    win;
  logic [7:0]    win_next;
  logic [OW-1:0] ones;
  logic [SW-1:0] se0_run;
  logic          nrzi_bit;

  assign win_next = {win, sym_j};
  assign nrzi_bit = (sym_j == prev_j);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt    <= 1'b0;
      drop      <= 1'b0;
      prev_j    <= 1'b1;
      win       <= '1;
      ones      <= '0;
      se0_run   <= '0;
      bit_vld   <= 1'b0;
      bit_val   <= 1'b0;
      sop       <= 1'b0;
      eop       <= 1'b0;
      stuff_err <= 1'b0;
      eop_err   <= 1'b0;
    end else begin
      bit_vld   <= 1'b0;
      sop       <= 1'b0;
      eop       <= 1'b0;
      stuff_err <= 1'b0;
      eop_err   <= 1'b0;
      if (sym_vld) begin
        if (!in_pkt) begin
          if (sym_se0) begin
            win <= '1;
          end else if (win_next == SYNC_PAT) begin
            in_pkt  <= 1'b1;
            sop     <= 1'b1;
            prev_j  <= sym_j;
            ones    <= '0;
            se0_run <= '0;
            drop    <= 1'b0;
            win     <= '1;
          end else begin
            win <= win_next[6:0];
          end
        end else if (sym_se0) begin
          if (se0_run != SE_LIM) se0_run <= se0_run + 1'b1;
        end else if (se0_run != '0) begin
          in_pkt  <= 1'b0;
          eop     <= 1'b1;
          eop_err <= (se0_run < SE_LIM) || !sym_j;
        end else begin
          prev_j <= sym_j;
          if (!drop) begin
            if (ones == ONES_LIM) begin
              if (nrzi_bit) begin
                stuff_err <= 1'b1;
                drop      <= 1'b1;
              end
              ones <= '0;
            end else begin
              bit_vld <= 1'b1;
              bit_val <= nrzi_bit;
              ones    <= nrzi_bit ? ones + 1'b1 : '0;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/srx_bytes.sv
module srx_bytes (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_vld,
  input  logic       bit_val,
  input  logic       sop,
  input  logic       eop,
  input  logic       stuff_err,
  input  logic       eop_err,
  output logic       byte_vld,
  output logic [7:0] byte_val,
  output logic       p_sop,
  output logic       p_eop,
  output logic       p_misalign,
  output logic       p_stuff,
  output logic       p_eop_err
);
  logic [6:0] sh;
  logic [2:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh         <= '0;
      cnt        <= '0;
      byte_vld   <= 1'b0;
      byte_val   <= '0;
      p_sop      <= 1'b0;
      p_eop      <= 1'b0;
      p_misalign <= 1'b0;
      p_stuff    <= 1'b0;
      p_eop_err  <= 1'b0;
    end else begin
      byte_vld   <= 1'b0;
      p_eop      <= 1'b0;
      p_sop      <= sop;
      p_stuff    <= stuff_err;
      if (sop) cnt <= '0;
      if (bit_vld) begin
        sh  <= {bit_val, sh[6:1]};
        cnt <= cnt + 1'b1;
        if (cnt == 3'd7) begin
          byte_vld <= 1'b1;
          byte_val <= {bit_val, sh};
        end
      end
      if (eop) begin
        p_eop      <= 1'b1;
        p_misalign <= (cnt != 3'd0);
        p_eop_err  <= eop_err;
      end
    end
  end

endmodule

// File: rtl/srx_parse.sv
module srx_parse
  import srx_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_vld,
  input  logic [7:0]  byte_val,
  input  logic        p_sop,
  input  logic        p_eop,
  input  logic        p_misalign,
  input  logic        p_stuff,
  input  logic        p_eop_err,
  output logic        pkt_vld,
  output logic [3:0]  pkt_type,
  output logic [6:0]  tok_addr,
  output logic [3:0]  tok_ep,
  output logic [10:0] tok_frame,
  output logic        err_pid,
  output logic        err_crc,
  output logic        err_stuff,
  output logic        err_eop,
  output logic        err_len,
  output logic        dat_vld,
  output logic [7:0]  dat_byte
);
  localparam logic [CNT_W-1:0] N0 = '0;
  localparam logic [CNT_W-1:0] N1 = CNT_W'(1);
  localparam logic [CNT_W-1:0] N2 = CNT_W'(2);
  localparam logic [CNT_W-1:0] N3 = CNT_W'(3);

  logic [CNT_W-1:0] nbytes;
  logic [3:0]       pid_r;
  logic             pid_ok;
  logic [15:0]      fld;
  logic             stf;

  pid_cls_e   cls;
  logic       addr_tok, sof_tok, pid_bad, len_bad, crc_bad;
  logic [4:0] crc_rx;

  assign cls      = classify(pid_r);
  assign addr_tok = pid_ok && (pid_r == PID_IN || pid_r == PID_OUT || pid_r == PID_SETUP);
  assign sof_tok  = pid_ok && (pid_r == PID_SOF);
  assign pid_bad  = (nbytes != N0) && !pid_ok;
  assign crc_rx   = {fld[11], fld[12], fld[13], fld[14], fld[15]};
  assign crc_bad  = pid_ok && (cls == CLS_TOKEN) && (nbytes == N3) &&
                    (crc_rx != crc5_calc(fld[10:0]));

  always_comb begin
    if (nbytes == N0)      len_bad = 1'b1;
    else if (!pid_ok)      len_bad = 1'b0;
    else begin
      case (cls)
        CLS_TOKEN: len_bad = (nbytes != N3);
        CLS_SHORT: len_bad = (nbytes != N1);
        default:   len_bad = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nbytes    <= '0;
      pid_r     <= '0;
      pid_ok    <= 1'b0;
      fld       <= '0;
      stf       <= 1'b0;
      pkt_vld   <= 1'b0;
      pkt_type  <= '0;
      tok_addr  <= '0;
      tok_ep    <= '0;
      tok_frame <= '0;
      err_pid   <= 1'b0;
      err_crc   <= 1'b0;
      err_stuff <= 1'b0;
      err_eop   <= 1'b0;
      err_len   <= 1'b0;
      dat_vld   <= 1'b0;
      dat_byte  <= '0;
    end else begin
      pkt_vld <= 1'b0;
      dat_vld <= 1'b0;
      if (p_sop) begin
        nbytes <= '0;
        pid_r  <= '0;
        pid_ok <= 1'b0;
        fld    <= '0;
        stf    <= 1'b0;
      end
      if (p_stuff) stf <= 1'b1;
      if (byte_vld) begin
        if (nbytes != '1) nbytes <= nbytes + 1'b1;
        if (nbytes == N0) begin
          pid_r  <= byte_val[3:0];
          pid_ok <= (byte_val[7:4] == ~byte_val[3:0]) &&
                    (classify(byte_val[3:0]) != CLS_BAD);
        end
        if (nbytes == N1) fld[7:0]  <= byte_val;
        if (nbytes == N2) fld[15:8] <= byte_val;
        dat_vld  <= (nbytes != N0) && pid_ok && (cls == CLS_DATA);
        dat_byte <= byte_val;
      end
      if (p_eop) begin
        pkt_vld   <= 1'b1;
        pkt_type  <= pid_r;
        tok_addr  <= addr_tok ? fld[6:0]  : '0;
        tok_ep    <= addr_tok ? fld[10:7] : '0;
        tok_frame <= sof_tok  ? fld[10:0] : '0;
        err_pid   <= pid_bad;
        err_crc   <= crc_bad;
        err_stuff <= stf | p_stuff;
        err_eop   <= p_misalign | p_eop_err;
        err_len   <= len_bad;
      end
    end
  end

endmodule

// File: rtl/srx_top.sv
module srx_top
  import srx_pkg::*;
#(
  parameter int RUN_MAX = 6,
  parameter int EOP_MIN = 2,
  parameter int CNT_W   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sym_vld,
  input  logic        sym_j,
  input  logic        sym_se0,
  output logic        pkt_vld,
  output logic [3:0]  pkt_type,
  output logic [6:0]  tok_addr,
  output logic [3:0]  tok_ep,
  output logic [10:0] tok_frame,
  output logic        err_pid,
  output logic        err_crc,
  output logic        err_stuff,
  output logic        err_eop,
  output logic        err_len,
  output logic        dat_vld,
  output logic [7:0]  dat_byte
);
  logic       w_bit_vld, w_bit_val, w_sop, w_eop, w_stuff, w_eop_err;
  logic       w_byte_vld;
  logic [7:0] w_byte_val;
  logic       w_p_sop, w_p_eop, w_p_mis, w_p_stuff, w_p_eop_err;

  srx_line #(.RUN_MAX(RUN_MAX), .EOP_MIN(EOP_MIN)) u_line (
    .clk(clk), .rst_n(rst_n),
    .sym_vld(sym_vld), .sym_j(sym_j), .sym_se0(sym_se0),
    .bit_vld(w_bit_vld), .bit_val(w_bit_val),
    .sop(w_sop), .eop(w_eop), .stuff_err(w_stuff), .eop_err(w_eop_err)
  );

  srx_bytes u_bytes (
    .clk(clk), .rst_n(rst_n),
    .bit_vld(w_bit_vld), .bit_val(w_bit_val),
    .sop(w_sop), .eop(w_eop), .stuff_err(w_stuff), .eop_err(w_eop_err),
    .byte_vld(w_byte_vld), .byte_val(w_byte_val),
    .p_sop(w_p_sop), .p_eop(w_p_eop), .p_misalign(w_p_mis),
    .p_stuff(w_p_stuff), .p_eop_err(w_p_eop_err)
  );

  srx_parse #(.CNT_W(CNT_W)) u_parse (
    .clk(clk), .rst_n(rst_n),
    .byte_vld(w_byte_vld), .byte_val(w_byte_val),
    .p_sop(w_p_sop), .p_eop(w_p_eop), .p_misalign(w_p_mis),
    .p_stuff(w_p_stuff), .p_eop_err(w_p_eop_err),
    .pkt_vld(pkt_vld), .pkt_type(pkt_type),
    .tok_addr(tok_addr), .tok_ep(tok_ep), .tok_frame(tok_frame),
    .err_pid(err_pid), .err_crc(err_crc), .err_stuff(err_stuff),
    .err_eop(err_eop), .err_len(err_len),
    .dat_vld(dat_vld), .dat_byte(dat_byte)
  );

endmodule

// File: rtl/srx_chk.sv
module srx_chk
  import srx_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        sym_vld,
  input logic        bit_vld,
  input logic        pkt_vld,
  input logic        dat_vld,
  input logic [3:0]  pkt_type,
  input logic [6:0]  tok_addr,
  input logic [3:0]  tok_ep,
  input logic [10:0] tok_frame,
  input logic        err_pid,
  input logic        err_crc,
  input logic        err_len
);
  logic is_addr_type, is_tok_type;
  assign is_addr_type = (pkt_type == PID_IN) || (pkt_type == PID_OUT) || (pkt_type == PID_SETUP);
  assign is_tok_type  = is_addr_type || (pkt_type == PID_SOF);

  // R10
  pkt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_vld |=> !pkt_vld);

  // R11
  data_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pkt_vld && dat_vld));

  // R12
  gap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_vld |=> !bit_vld);

  // R5
  addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_vld && !is_addr_type) |-> (tok_addr == '0 && tok_ep == '0));

  // R6
  frame_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_vld && pkt_type != PID_SOF) |-> (tok_frame == '0));

  // R8
  pid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_vld && err_pid) |-> (!err_len && !err_crc));

  // R7
  crc_tok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_vld && err_crc) |-> is_tok_type);

endmodule

bind srx_top srx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sym_vld(sym_vld), .bit_vld(w_bit_vld),
  .pkt_vld(pkt_vld), .dat_vld(dat_vld), .pkt_type(pkt_type),
  .tok_addr(tok_addr), .tok_ep(tok_ep), .tok_frame(tok_frame),
  .err_pid(err_pid), .err_crc(err_crc), .err_len(err_len)
);

// File: tb/sim_srx_top.sv
`timescale 1ns/1ps
module sim_srx_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, sym_vld, sym_j, sym_se0;
  logic        pkt_vld, err_pid, err_crc, err_stuff, err_eop, err_len, dat_vld;
  logic [3:0]  pkt_type, tok_ep;
  logic [6:0]  tok_addr;
  logic [10:0] tok_frame;
  logic [7:0]  dat_byte;

  srx_top u0 (
    .clk(clk), .rst_n(rst_n), .sym_vld(sym_vld), .sym_j(sym_j), .sym_se0(sym_se0),
    .pkt_vld(pkt_vld), .pkt_type(pkt_type), .tok_addr(tok_addr), .tok_ep(tok_ep),
    .tok_frame(tok_frame), .err_pid(err_pid), .err_crc(err_crc), .err_stuff(err_stuff),
    .err_eop(err_eop), .err_len(err_len), .dat_vld(dat_vld), .dat_byte(dat_byte)
  );

  typedef struct {
    logic [3:0]  typ;
    logic [6:0]  addr;
    logic [3:0]  ep;
    logic [10:0] frame;
    logic [4:0]  err;   // {pid, crc, stuff, eop, len}
    string       req;
  } exp_t;
  typedef struct {
    logic [7:0] b;
    string      req;
  } dexp_t;

  exp_t  pq[$];
  dexp_t dq[$];
  logic  bq[$];
  bit    gap = 1'b0;
  int    n_run = 0, n_fail = 0, n_pkt = 0;
  bit    done = 1'b0;

  // Monitor: pops the scoreboard as reports and bytes appear.
  always @(negedge clk) begin
    exp_t  e;
    dexp_t d;
    if (rst_n && !done) begin
      if (pkt_vld) begin
        n_pkt++;
        n_run++;
        if (pq.size() == 0) begin
          n_fail++;
          $display("FAIL R1 R10 unexpected report type=%h, expected none", pkt_type);
        end else begin
          e = pq.pop_front();
          if ({pkt_type, tok_addr, tok_ep, tok_frame,
               err_pid, err_crc, err_stuff, err_eop, err_len} !==
              {e.typ, e.addr, e.ep, e.frame, e.err}) begin
            n_fail++;
            $display("FAIL %s got typ=%h addr=%h ep=%h frame=%h err=%b, expected typ=%h addr=%h ep=%h frame=%h err=%b",
                     e.req, pkt_type, tok_addr, tok_ep, tok_frame,
                     {err_pid, err_crc, err_stuff, err_eop, err_len},
                     e.typ, e.addr, e.ep, e.frame, e.err);
          end
        end
      end
      if (dat_vld) begin
        n_run++;
        if (dq.size() == 0) begin
          n_fail++;
          $display("FAIL R11 unexpected data byte %h, expected none", dat_byte);
        end else begin
          d = dq.pop_front();
          if (dat_byte !== d.b) begin
            n_fail++;
            $display("FAIL %s data byte got %h, expected %h", d.req, dat_byte, d.b);
          end
        end
      end
    end
  end

  function automatic logic [4:0] tb_crc(input logic [10:0] v);
    logic [4:0] s = 5'h1F;
    for (int k = 0; k < 11; k++) begin
      if (s[4] ^ v[k]) s = {s[3:0], 1'b0} ^ 5'h05;
      else             s = {s[3:0], 1'b0};
    end
    return ~s;
  endfunction

  task automatic add_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) bq.push_back(b[i]);
  endtask

  task automatic expect_pkt(input logic [3:0] t, input logic [6:0] a, input logic [3:0] ep,
                            input logic [10:0] f, input logic [4:0] er, input string r);
    exp_t e;
    e.typ = t; e.addr = a; e.ep = ep; e.frame = f; e.err = er; e.req = r;
    pq.push_back(e);
  endtask

  task automatic expect_dat(input logic [7:0] b, input string r);
    dexp_t d;
    d.b = b; d.req = r;
    dq.push_back(d);
  endtask

  task automatic put_sym(input logic j, input logic s);
    @(negedge clk);
    sym_vld = 1'b1; sym_j = j; sym_se0 = s;
    if (gap) begin
      @(negedge clk);
      sym_vld = 1'b0;
    end
  endtask

  task automatic add_token(input logic [3:0] p, input logic [10:0] v, input bit bad);
    logic [4:0]  c;
    logic [15:0] f;
    c = tb_crc(v);
    f = {c[0], c[1], c[2], c[3], c[4], v};
    if (bad) f[15] = ~f[15];
    add_byte({~p, p});
    add_byte(f[7:0]);
    add_byte(f[15:8]);
  endtask

  task automatic send(input bit stuff_en, input int se0_n, input logic end_j);
    logic line;
    int   ones;
    repeat (3) put_sym(1'b1, 1'b0);
    for (int i = 7; i >= 0; i--) put_sym(srx_pkg::SYNC_PAT[i], 1'b0);
    line = 1'b0;
    ones = 0;
    foreach (bq[i]) begin
      if (bq[i]) ones++;
      else begin line = ~line; ones = 0; end
      put_sym(line, 1'b0);
      if (stuff_en && ones == 6) begin
        line = ~line;
        put_sym(line, 1'b0);
        ones = 0;
      end
    end
    repeat (se0_n) put_sym(1'b0, 1'b1);
    put_sym(end_j, 1'b0);
    repeat (2) put_sym(1'b1, 1'b0);
    @(negedge clk);
    sym_vld = 1'b0;
    bq.delete();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired, got hang, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int pkts_before;
    rst_n = 1'b0; sym_vld = 1'b0; sym_j = 1'b1; sym_se0 = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_run++;
    if (pkt_vld !== 1'b0 || dat_vld !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 reset outputs got pkt_vld=%b dat_vld=%b, expected 0 0", pkt_vld, dat_vld);
    end

    // R2 R5 R7: IN token, symbols every clock
    expect_pkt(4'h9, 7'h15, 4'h3, 11'h0, 5'b00000, "R2 R5 R7 IN token");
    add_token(4'b1001, {4'h3, 7'h15}, 1'b0); send(1'b1, 2, 1'b1);

    // R12 R3 R5: OUT token of all ones with idle clocks between symbols
    gap = 1'b1;
    expect_pkt(4'h1, 7'h7F, 4'hF, 11'h0, 5'b00000, "R12 R3 R5 OUT with gaps");
    add_token(4'b0001, 11'h7FF, 1'b0); send(1'b1, 2, 1'b1);
    gap = 1'b0;

    // R7: SETUP with one flipped check bit
    expect_pkt(4'hD, 7'h00, 4'h0, 11'h0, 5'b01000, "R7 bad check value");
    add_token(4'b1101, 11'h000, 1'b1); send(1'b1, 2, 1'b1);

    // R6: SOF frame number
    expect_pkt(4'h5, 7'h00, 4'h0, 11'h7AB, 5'b00000, "R6 SOF frame");
    add_token(4'b0101, 11'h7AB, 1'b0); send(1'b1, 2, 1'b1);

    // R4: handshake
    expect_pkt(4'h2, 7'h00, 4'h0, 11'h0, 5'b00000, "R4 ACK");
    add_byte(8'hD2); send(1'b1, 2, 1'b1);

    // R11 R3: DATA0 with long runs
    expect_pkt(4'h3, 7'h00, 4'h0, 11'h0, 5'b00000, "R11 DATA0 report");
    expect_dat(8'hFF, "R3 R11"); expect_dat(8'hFF, "R3 R11");
    expect_dat(8'h00, "R11");    expect_dat(8'h3C, "R11");
    add_byte(8'hC3); add_byte(8'hFF); add_byte(8'hFF); add_byte(8'h00); add_byte(8'h3C);
    send(1'b1, 2, 1'b1);

    // R11 R12: DATA1 with gaps
    gap = 1'b1;
    expect_pkt(4'hB, 7'h00, 4'h0, 11'h0, 5'b00000, "R11 R12 DATA1 report");
    expect_dat(8'h80, "R11 R12"); expect_dat(8'h01, "R11 R12");
    add_byte(8'h4B); add_byte(8'h80); add_byte(8'h01); send(1'b1, 2, 1'b1);
    gap = 1'b0;

    // R4: complement mismatch, then undefined code
    expect_pkt(4'h1, 7'h00, 4'h0, 11'h0, 5'b10000, "R4 complement mismatch");
    add_byte(8'h11); send(1'b1, 2, 1'b1);
    expect_pkt(4'h0, 7'h00, 4'h0, 11'h0, 5'b10000, "R4 undefined code");
    add_byte(8'hF0); send(1'b1, 2, 1'b1);

    // R8: short token, long handshake, empty packet
    expect_pkt(4'h9, 7'h12, 4'h0, 11'h0, 5'b00001, "R8 short token");
    add_byte(8'h69); add_byte(8'h12); send(1'b1, 2, 1'b1);
    expect_pkt(4'hA, 7'h00, 4'h0, 11'h0, 5'b00001, "R8 long NAK");
    add_byte(8'h5A); add_byte(8'h00); send(1'b1, 2, 1'b1);
    expect_pkt(4'h0, 7'h00, 4'h0, 11'h0, 5'b00001, "R8 empty packet");
    send(1'b1, 2, 1'b1);

    // R3: seventh 1 bit without a stuffed bit (12 bits kept, so partial byte too)
    expect_pkt(4'h2, 7'h00, 4'h0, 11'h0, 5'b00110, "R3 stuff error");
    add_byte(8'hD2); add_byte(8'hFF); send(1'b0, 2, 1'b1);

    // R9: partial byte, one-symbol SE0, K after SE0, long SE0
    expect_pkt(4'h2, 7'h00, 4'h0, 11'h0, 5'b00010, "R9 partial byte");
    add_byte(8'hD2); bq.push_back(1'b1); bq.push_back(1'b0); bq.push_back(1'b1);
    send(1'b1, 2, 1'b1);
    expect_pkt(4'h2, 7'h00, 4'h0, 11'h0, 5'b00010, "R9 single SE0");
    add_byte(8'hD2); send(1'b1, 1, 1'b1);
    expect_pkt(4'h2, 7'h00, 4'h0, 11'h0, 5'b00010, "R9 K after SE0");
    add_byte(8'hD2); send(1'b1, 2, 1'b0);
    expect_pkt(4'h2, 7'h00, 4'h0, 11'h0, 5'b00000, "R9 long SE0");
    add_byte(8'hD2); send(1'b1, 3, 1'b1);

    // R1: sync-like noise without the exact sequence
    pkts_before = n_pkt;
    begin
      logic [15:0] noise = 16'b0101_0101_0101_0110;
      for (int i = 15; i >= 0; i--) put_sym(noise[i], 1'b0);
      put_sym(1'b0, 1'b0); put_sym(1'b1, 1'b0); put_sym(1'b0, 1'b1);
      put_sym(1'b1, 1'b0); put_sym(1'b0, 1'b0); put_sym(1'b0, 1'b0);
      put_sym(1'b0, 1'b1); put_sym(1'b0, 1'b1); put_sym(1'b1, 1'b0);
      repeat (10) put_sym(1'b1, 1'b0);
      @(negedge clk); sym_vld = 1'b0;
      repeat (6) @(negedge clk);
    end
    n_run++;
    if (n_pkt != pkts_before) begin
      n_fail++;
      $display("FAIL R1 noise produced reports got %0d, expected 0", n_pkt - pkts_before);
    end

    repeat (10) @(negedge clk);
    n_run++;
    if (pq.size() != 0 || dq.size() != 0) begin
      n_fail++;
      $display("FAIL R10 R11 missing items got pending=%0d/%0d, expected 0/0", pq.size(), dq.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule